// File: doc/BRIEF.md
# Buffered Two-Channel PWM Compare Unit

This block is a timer that drives two pulse-width outputs from one shared counter. The counter runs at a resolution of 8, 9 or 10 bits. It has two counting schemes. In single-slope mode it counts from zero up to the ceiling and wraps back to zero. In dual-slope mode it counts up to the ceiling and then back down again. The ceiling (TOP) is 2^N−1 for a resolution of N bits. Each channel has a two-bit output mode. The mode either disconnects the pin, which then sits low, or selects the non-inverted or inverted waveform.

Software writes compare values over a simple strobe bus. A write does not reach the compare logic directly. It lands in a per-channel holding register, and the holding register is copied to the active compare register only on the clock edge where the counter sits at TOP. A compare value written part-way through a period therefore takes effect only from the next whole period, and no period comes out with an odd length. A read of a compare register always returns the holding register, which is the value most recently written. The block also keeps sticky flags: one for counter overflow and one for a compare match on each channel. Writing 1 to a flag clears it.

Top module: `pwm_buf_top`

## Requirements
- R1: `cfg_res` selects the resolution: 00 gives 8 bits (TOP 255), 01 gives 9 bits (TOP 511), and 10 or 11 give 10 bits (TOP 1023). The counter never goes above TOP. A compare write keeps only the low N bits of `bus_wdata`.
- R2: A write with `bus_sel`=00 (channel A) or 01 (channel B) loads that channel's holding register. The active compare value changes only on the edge where the counter equals TOP, and it then takes the holding value held before that edge. If two writes fall in one period, the last one wins.
- R3: `bus_rdata` returns the holding register of channel A when `bus_rsel`=0 and of channel B when `bus_rsel`=1. The new value is visible in the cycle after the write, before any latch at TOP.
- R4: With `cfg_dual`=0 the counter steps 0,1,…,TOP,0,… so a period is TOP+1 cycles. `flag_ovf` is set on the edge where the counter wraps from TOP.
- R5: With `cfg_dual`=1 the counter steps 0,1,…,TOP,TOP−1,…,1,0,1,… so a period is 2·TOP cycles. `flag_ovf` is set on the edge where the counter leaves 0.
- R6: In single-slope mode with output mode 10 and active compare value C, the output is high for C+1 cycles of each period, from count 0 up to count C. When C=TOP the output stays high for the whole period. Output mode 11 gives the complement.
- R7: In dual-slope mode with output mode 10, the output is high while the count is below C. That makes 2·C−1 high cycles per period when 0<C<TOP, none when C=0 (constant low), and all of them when C=TOP (constant high). Output mode 11 gives the complement, so C=0 is constant high and C=TOP is constant low.
- R8: Output modes 00 and 01 hold the channel's output low.
- R9: A channel's compare flag is set on every edge where the count equals its active compare value. Flags stay set until cleared. A write with `bus_sel`=10 clears `flag_ovf` if data bit 0 is 1, `flag_cmp_a` if bit 1 is 1, and `flag_cmp_b` if bit 2 is 1. A flag that is set and cleared on the same edge ends up set.
- R10: Every complete period, whether it is measured from count 0 to TOP (single-slope) or from the cycle after TOP up to the next TOP (dual-slope), has exactly the high time set by one compare value. That value is either the one active before a mid-period write or the one written, and never a mix of the two.
- R11: A synchronous reset sets the counter, the holding and active compare registers, and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_res | input | 2 | Resolution select |
| cfg_dual | input | 1 | 1 = dual-slope counting, 0 = single-slope |
| cfg_mode_a | input | 2 | Output mode of channel A |
| cfg_mode_b | input | 2 | Output mode of channel B |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 2 | Write target: 00 compare A, 01 compare B, 10 flag clear |
| bus_wdata | input | 10 | Write data |
| bus_rsel | input | 1 | Readback select: 0 channel A, 1 channel B |
| bus_rdata | output | 10 | Holding register of the selected channel |
| cnt_val | output | 10 | Current counter value |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Channel A compare flag |
| flag_cmp_b | output | 1 | Channel B compare flag |

## Verification
The bench runs the waveform with mid-range compare values, with 0 and with TOP, in both counting schemes and in all four output modes. This separates the plain compare level from the forced constant levels and from the disconnected pin. Compare writes are placed part-way through a period at points where the counter has passed the new value but not the old one, and two writes are placed in one period. A scoreboard counts the high cycles of every whole period and compares them with the width of the value that should be active. An early latch, a late latch or a lost last-write shows up as a period with the wrong width. The bench also reads the holding register back before TOP, writes values wider than the resolution, and clears the flags at counts where no event can set them again.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;

    localparam int CNT_W   = 10;
    localparam int MIN_RES = 8;
    localparam int NCH     = 2;
    localparam int RES_SELW = 2;

    typedef logic [CNT_W-1:0] cval_t;

    typedef enum logic [1:0] {
        WS_CMP_A = 2'b00,
        WS_CMP_B = 2'b01,
        WS_FLAGS = 2'b10,
        WS_NONE  = 2'b11
    } wsel_e;

    typedef enum logic [1:0] {
        OM_DISC0  = 2'b00,
        OM_DISC1  = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV    = 2'b11
    } omode_e;

    typedef struct packed {
        cval_t cnt;
        cval_t top;
        logic  up;
        logic  at_top;
        logic  ovf_evt;
    } tick_t;

    // Ceiling for a resolution code; code 3 is treated as the widest setting.
    function automatic cval_t top_of(input logic [RES_SELW-1:0] code);
        int n;
        n = MIN_RES + ((code == 2'b11) ? 2 : int'(code));
        return cval_t'((1 << n) - 1);
    endfunction

    // Output level decoded from the registered count and active compare value.
    function automatic logic wave(input logic dual, input omode_e m,
                                  input cval_t cnt, input cval_t act, input cval_t top);
        logic base;
        if (dual) base = (act == top) || (cnt < act);
        else      base = (cnt <= act);
        case (m)
            OM_NONINV: return base;
            OM_INV:    return !base;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_buf_counter.sv
module pwm_buf_counter
    import pwm_buf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [RES_SELW-1:0] res,
    input  logic                dual,
    input  logic                ovf_clr,
    output tick_t               tick,
    output logic                ovf_flag
);

    cval_t cnt_q, cnt_d, top;
    logic  up_q, up_d;
    logic  at_top, ovf_evt;

    always_comb begin
        top     = top_of(res);
        at_top  = (cnt_q >= top);
        ovf_evt = dual ? (cnt_q == '0) : at_top;
    end

    always_comb begin
        cnt_d = cnt_q;
        up_d  = up_q;
        if (!dual) begin
            up_d  = 1'b1;
            cnt_d = at_top ? '0 : cnt_q + cval_t'(1);
        end else if (up_q) begin
            if (at_top) begin
                cnt_d = top - cval_t'(1);
                up_d  = 1'b0;
            end else begin
                cnt_d = cnt_q + cval_t'(1);
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_d = cval_t'(1);
                up_d  = 1'b1;
            end else begin
                cnt_d = cnt_q - cval_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            up_q     <= 1'b1;
            ovf_flag <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        tick.cnt     = cnt_q;
        tick.top     = top;
        tick.up      = up_q;
        tick.at_top  = at_top;
        tick.ovf_evt = ovf_evt;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= top) |=> (cnt_q <= top) || !$stable(res));  // R1
    AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!dual && cnt_q == top) |=> (cnt_q == '0) || !$stable(dual) || !$stable(res));  // R4
    AST_DUAL_LEAVE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dual && cnt_q == '0) |=> (cnt_q == cval_t'(1)) || !$stable(dual));  // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);  // R4

endmodule

// File: rtl/pwm_buf_channel.sv
module pwm_buf_channel
    import pwm_buf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dual,
    input  omode_e mode,
    input  tick_t  tick,
    input  logic   wr,
    input  cval_t  wdata,
    input  logic   flag_clr,
    output cval_t  shadow,
    output logic   pwm,
    output logic   flag
);

    cval_t sh_q, act_q;
    logic  match;

    always_comb match = (tick.cnt == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            act_q <= '0;
            flag  <= 1'b0;
        end else begin
            if (wr)          sh_q  <= wdata & tick.top;
            if (tick.at_top) act_q <= sh_q & tick.top;
            if (match)         flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    always_comb begin
        shadow = sh_q;
        pwm    = wave(dual, mode, tick.cnt, act_q, tick.top);
    end

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick.at_top |=> $stable(act_q));  // R2
    AST_LATCH_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        tick.at_top |=> (act_q == ($past(sh_q) & $past(tick.top))));  // R2
    AST_TOP_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_NONINV && act_q == tick.top) |-> pwm);  // R6
    AST_DISC_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_DISC0 || mode == OM_DISC1) |-> !pwm);  // R8
    AST_CMP_FLAG: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);  // R9

endmodule

// File: rtl/pwm_buf_top.sv
module pwm_buf_top
    import pwm_buf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [RES_SELW-1:0] cfg_res,
    input  logic                cfg_dual,
    input  logic [1:0]          cfg_mode_a,
    input  logic [1:0]          cfg_mode_b,
    input  logic                bus_wr,
    input  logic [1:0]          bus_sel,
    input  logic [CNT_W-1:0]    bus_wdata,
    input  logic                bus_rsel,
    output logic [CNT_W-1:0]    bus_rdata,
    output logic [CNT_W-1:0]    cnt_val,
    output logic                pwm_a,
    output logic                pwm_b,
    output logic                flag_ovf,
    output logic                flag_cmp_a,
    output logic                flag_cmp_b
);

    tick_t  tick;
    omode_e mode_v [NCH];
    cval_t  sh_v   [NCH];
    logic   pwm_v  [NCH];
    logic   flag_v [NCH];
    logic   flag_wr;

    always_comb begin
        mode_v[0] = omode_e'(cfg_mode_a);
        mode_v[1] = omode_e'(cfg_mode_b);
        flag_wr   = bus_wr && (wsel_e'(bus_sel) == WS_FLAGS);
    end

    pwm_buf_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .res      (cfg_res),
        .dual     (cfg_dual),
        .ovf_clr  (flag_wr && bus_wdata[0]),
        .tick     (tick),
        .ovf_flag (flag_ovf)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_buf_channel u_channel (
            .clk      (clk),
            .rst      (rst),
            .dual     (cfg_dual),
            .mode     (mode_v[ch]),
            .tick     (tick),
            .wr       (bus_wr && (bus_sel == 2'(ch))),
            .wdata    (bus_wdata),
            .flag_clr (flag_wr && bus_wdata[1 + ch]),
            .shadow   (sh_v[ch]),
            .pwm      (pwm_v[ch]),
            .flag     (flag_v[ch])
        );
    end

    always_comb begin
        bus_rdata  = bus_rsel ? sh_v[1] : sh_v[0];
        cnt_val    = tick.cnt;
        pwm_a      = pwm_v[0];
        pwm_b      = pwm_v[1];
        flag_cmp_a = flag_v[0];
        flag_cmp_b = flag_v[1];
    end

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && bus_wdata[1] && tick.cnt != sh_v[0] && !flag_cmp_a) |=> !flag_cmp_a || $past(tick.at_top));  // R9

endmodule

// File: tb/pwm_buf_top_bench.sv
module pwm_buf_top_bench;
    import pwm_buf_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_res = 2'b00;
    logic       cfg_dual = 1'b0;
    logic [1:0] cfg_mode_a = 2'b10, cfg_mode_b = 2'b11;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'b11;
    logic [9:0] bus_wdata = '0;
    logic       bus_rsel = 1'b0;
    logic [9:0] bus_rdata, cnt_val;
    logic       pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b;

    always #2 clk = ~clk;

    pwm_buf_top u_pwm_buf_top (
        .clk(clk), .rst(rst), .cfg_res(cfg_res), .cfg_dual(cfg_dual),
        .cfg_mode_a(cfg_mode_a), .cfg_mode_b(cfg_mode_b),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rsel(bus_rsel), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_ovf(flag_ovf),
        .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b)
    );

    int total = 0, bad = 0;
    int b_top = 255;
    bit b_dual = 1'b0;

    typedef struct { int ch; int val; } wr_item_t;
    wr_item_t wq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_high(input bit dual, input logic [1:0] m, input int c, input int top);
        int per, h;
        per = dual ? 2 * top : top + 1;
        if (dual) h = (c == 0) ? 0 : (c >= top) ? 2 * top : 2 * c - 1;
        else      h = (c >= top) ? top + 1 : c + 1;
        if (m == 2'b10) return h;
        if (m == 2'b11) return per - h;
        return 0;
    endfunction

    // Monitor / scoreboard
    int  sh[2], act[2], hi[2], prev_act[2];
    int  prev_cnt, c, exp_c;
    bit  prev_valid, armed, mdl_up;
    wr_item_t it;

    always @(negedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                sh[k] = 0; act[k] = 0; hi[k] = 0; prev_act[k] = 0;
            end
            prev_valid = 0; armed = 0; mdl_up = 1;
        end else begin
            c = int'(cnt_val);
            chk(c <= b_top, "R1 counter bound", c, b_top);
            if (prev_valid) begin
                if (!b_dual) begin
                    exp_c = (prev_cnt == b_top) ? 0 : prev_cnt + 1;
                    chk(c == exp_c, "R4 count step", c, exp_c);
                    if (prev_cnt == b_top) chk(flag_ovf == 1'b1, "R4 overflow flag", int'(flag_ovf), 1);
                end else begin
                    if (mdl_up) begin
                        if (prev_cnt == b_top) begin exp_c = b_top - 1; mdl_up = 0; end
                        else exp_c = prev_cnt + 1;
                    end else begin
                        if (prev_cnt == 0) begin exp_c = 1; mdl_up = 1; end
                        else exp_c = prev_cnt - 1;
                    end
                    chk(c == exp_c, "R5 count step", c, exp_c);
                    if (prev_cnt == 0) chk(flag_ovf == 1'b1, "R5 overflow flag", int'(flag_ovf), 1);
                end
                if (prev_cnt == prev_act[0]) chk(flag_cmp_a == 1'b1, "R9 compare flag A", int'(flag_cmp_a), 1);
                if (prev_cnt == prev_act[1]) chk(flag_cmp_b == 1'b1, "R9 compare flag B", int'(flag_cmp_b), 1);
            end
            hi[0] += int'(pwm_a);
            hi[1] += int'(pwm_b);
            prev_act = act;
            if (c == b_top) begin
                if (armed) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [1:0] m;
                        int e;
                        string req;
                        m = (k == 0) ? cfg_mode_a : cfg_mode_b;
                        e = exp_high(b_dual, m, act[k], b_top);
                        req = (m < 2'b10) ? "R8 period width" : (b_dual ? "R7 R10 R2 period width" : "R6 R10 R2 period width");
                        chk(hi[k] == e, $sformatf("%s ch%0d", req, k), hi[k], e);
                    end
                end
                armed = 1;
                hi[0] = 0; hi[1] = 0;
                act = sh;
            end
            if (bus_wr && bus_sel < 2'b10) begin
                if (wq.size() == 0) chk(1'b0, "R2 write queue", 0, 1);
                else begin
                    it = wq.pop_front();
                    sh[it.ch] = it.val & b_top;
                end
            end
            prev_cnt = c;
            prev_valid = 1;
        end
    end

    task automatic wr_cmp(input int ch, input int v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = 2'(ch); bus_wdata = 10'(v);
        wq.push_back('{ch, v});
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 2'b11;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt_val) != v);
    endtask

    task automatic do_reset(input logic [1:0] r, input bit d, input logic [1:0] ma, input logic [1:0] mb);
        @(posedge clk); #1;
        rst = 1'b1; cfg_res = r; cfg_dual = d; cfg_mode_a = ma; cfg_mode_b = mb;
        b_top = (1 << (8 + ((r == 2'b11) ? 2 : int'(r)))) - 1;
        b_dual = d;
        wq.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cnt_val == 0, "R11 reset counter", int'(cnt_val), 0);
        chk({flag_ovf, flag_cmp_a, flag_cmp_b} == 3'b000, "R11 reset flags",
            int'({flag_ovf, flag_cmp_a, flag_cmp_b}), 0);
        bus_rsel = 1'b1;
        #0.5 chk(bus_rdata == 0, "R11 reset holding B", int'(bus_rdata), 0);
        bus_rsel = 1'b0;
        #0.5 chk(bus_rdata == 0, "R11 reset holding A", int'(bus_rdata), 0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        // Phase 1: 8-bit single-slope, channel A non-inverted, B inverted
        do_reset(2'b00, 1'b0, 2'b10, 2'b11);
        wr_cmp(0, 100);
        bus_rsel = 1'b0; #0.5;
        chk(bus_rdata == 100, "R3 readback before TOP", int'(bus_rdata), 100);
        wr_cmp(1, 'h3A5);
        bus_rsel = 1'b1; #0.5;
        chk(bus_rdata == 'hA5, "R1 R3 write masked to 8 bits", int'(bus_rdata), 'hA5);
        repeat (3) wait_cnt(255);
        wait_cnt(200);
        chk({flag_ovf, flag_cmp_a, flag_cmp_b} == 3'b111, "R9 flags set",
            int'({flag_ovf, flag_cmp_a, flag_cmp_b}), 7);
        wait_cnt(10);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = 2'b10; bus_wdata = 10'b111;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 2'b11;
        @(negedge clk);
        chk({flag_ovf, flag_cmp_a, flag_cmp_b} == 3'b000, "R9 flags cleared",
            int'({flag_ovf, flag_cmp_a, flag_cmp_b}), 0);
        wait_cnt(120);
        chk(flag_cmp_a == 1'b1 && flag_ovf == 1'b0, "R9 compare A set again, overflow stays clear",
            int'({flag_ovf, flag_cmp_a}), 1);
        wait_cnt(60);
        wr_cmp(0, 20);
        wait_cnt(80);
        chk(pwm_a == 1'b1, "R2 old width kept until TOP", int'(pwm_a), 1);
        repeat (2) wait_cnt(255);
        wait_cnt(30);
        wr_cmp(0, 200);
        wr_cmp(0, 10);
        wr_cmp(1, 255);
        repeat (3) wait_cnt(255);
        wait_cnt(128);
        chk(pwm_b == 1'b0, "R6 inverted TOP held low", int'(pwm_b), 0);
        wr_cmp(0, 0);
        repeat (2) wait_cnt(255);

        // Phase 2: 9-bit dual-slope
        do_reset(2'b01, 1'b1, 2'b10, 2'b11);
        wr_cmp(0, 100);
        wr_cmp(1, 511);
        repeat (2) wait_cnt(511);
        wait_cnt(50);
        wr_cmp(0, 300);
        wr_cmp(1, 0);
        wait_cnt(200);
        wr_cmp(0, 510);
        bus_rsel = 1'b0; #0.5;
        chk(bus_rdata == 510, "R3 readback of newest value", int'(bus_rdata), 510);
        repeat (3) wait_cnt(511);
        wait_cnt(5);
        chk(pwm_b == 1'b1, "R7 inverted zero held high", int'(pwm_b), 1);

        // Phase 3: code 11 gives 10-bit single-slope, disconnected outputs
        do_reset(2'b11, 1'b0, 2'b00, 2'b01);
        wr_cmp(0, 500);
        wr_cmp(1, 1023);
        repeat (3) wait_cnt(1023);
        wait_cnt(300);
        chk(pwm_a == 1'b0 && pwm_b == 1'b0, "R8 disconnected outputs low",
            int'({pwm_a, pwm_b}), 0);

        // Phase 4: 10-bit dual-slope with zero and TOP
        do_reset(2'b10, 1'b1, 2'b10, 2'b11);
        wr_cmp(0, 0);
        wr_cmp(1, 1023);
        repeat (3) wait_cnt(1023);
        wait_cnt(3);
        chk(pwm_a == 1'b0 && pwm_b == 1'b0, "R7 zero low and inverted TOP low",
            int'({pwm_a, pwm_b}), 0);
        wr_cmp(0, 1023);
        repeat (2) wait_cnt(1023);
        wait_cnt(700);
        chk(pwm_a == 1'b1, "R7 TOP held high", int'(pwm_a), 1);

        summary();
    end

endmodule